// File: doc/BRIEF.md
# Strobe-Handshaked FIFO with Level Flags

This block is a first-in first-out store of 64 words, 5 bits wide, running on one system clock. A producer offers a word by raising a write strobe while the block signals that it will take input. A consumer takes the presented word by raising a read strobe while the block signals that a valid word sits on its output. Only the rising edge of either strobe counts, and an edge that arrives while the matching ready signal is low does nothing.

Each accepted write pulls the write-ready signal down for one cycle, after which it comes back only if room remains. Each accepted read pulls the read-ready signal down for one cycle while the next word is fetched. Two flags track the stored word count: one marks the two ends (nearly empty or nearly full), the other marks the upper half. An active-low output enable forces the data output to zero instead of a high-impedance state.

Top module: `shift_fifo`

## Requirements
- R1: While `clear_n` is low at a clock edge the block resets synchronously: count zero, `wr_rdy` = 1, `rd_rdy` = 0, `edge_flag` = 1, `half_flag` = 0.
- R2: A word on `wr_data` is stored at the first clock edge where `wr_strobe` is sampled high after being low and `wr_rdy` is high; `wr_rdy` is low in the following cycle and returns high one cycle later if fewer than 64 words are held.
- R3: A write strobe held high for several cycles stores exactly one word; no word is stored for a strobe edge seen while `wr_rdy` is low.
- R4: With 64 words held, `wr_rdy` stays low; it is high again in the cycle after a read is accepted.
- R5: Words leave on `rd_data` in the order they were written.
- R6: `rd_rdy` rises one cycle after a word enters an empty store; after an accepted read it is low for exactly one cycle and then high if any word remains.
- R7: A read strobe edge while `rd_rdy` is low removes nothing and changes no count.
- R8: `edge_flag` is 1 exactly when the count is 8 or less or 56 or more, updated in the same cycle as the count.
- R9: `half_flag` is 1 exactly when the count is 32 or more, updated in the same cycle as the count.
- R10: A write and a read accepted at the same edge leave the count unchanged.
- R11: While `out_en_n` is high, `rd_data` is all zeros.
- R12: Asserting `clear_n` discards every stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clear_n | input | 1 | Synchronous reset, active low |
| wr_strobe | input | 1 | Write strobe, rising edge requests a store |
| wr_data | input | 5 | Word to store |
| wr_rdy | output | 1 | High when a write strobe edge will be accepted |
| rd_strobe | input | 1 | Read strobe, rising edge removes the presented word |
| rd_rdy | output | 1 | High when `rd_data` holds a valid word |
| out_en_n | input | 1 | Output enable, active low; high forces `rd_data` to zero |
| rd_data | output | 5 | Oldest stored word |
| edge_flag | output | 1 | Count at or below 8, or at or above 56 |
| half_flag | output | 1 | Count at or above 32 |

## Verification
A strobe driven high at a falling edge is taken at the next rising edge; the count, both flags and the drop of the matching ready signal are due right after that edge, so the bench samples them at the next falling edge. The recovery of `wr_rdy` and the rise of `rd_rdy` with the next word each need one further edge, and the bench samples them one falling edge later. `rd_data` gated by `out_en_n` is combinational and is checked at the falling edge after the enable changes. Every step of full fill and full drain is compared against a count and word list kept in the bench.

// File: rtl/shift_fifo_pkg.sv
package shift_fifo_pkg;
  typedef struct packed {
    logic ends;
    logic half;
  } lvl_flags_t;
endpackage

// File: rtl/strobe_rise.sv
module strobe_rise (
  input  logic clk,
  input  logic clear_n,
  input  logic strobe,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!clear_n) prev_q <= 1'b0;
    else          prev_q <= strobe;
  end

  assign rise = strobe & ~prev_q;
endmodule

// File: rtl/fifo_ram.sv
module fifo_ram #(
  parameter int WIDTH = 5,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fifo_level.sv
module fifo_level
  import shift_fifo_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int LOW_MARK = 8,
  parameter int HIGH_MARK = 56,
  parameter int HALF_MARK = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          clear_n,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_n,
  output lvl_flags_t    flags_q
);
  localparam logic [CW-1:0] LOW_C  = CW'(LOW_MARK);
  localparam logic [CW-1:0] HIGH_C = CW'(HIGH_MARK);
  localparam logic [CW-1:0] HALF_C = CW'(HALF_MARK);

  always_comb begin
    unique case ({inc, dec})
      2'b10:   cnt_n = cnt_q + 1'b1;
      2'b01:   cnt_n = cnt_q - 1'b1;
      default: cnt_n = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!clear_n) begin
      cnt_q        <= '0;
      flags_q.ends <= 1'b1;
      flags_q.half <= 1'b0;
    end else begin
      cnt_q        <= cnt_n;
      flags_q.ends <= (cnt_n <= LOW_C) || (cnt_n >= HIGH_C);
      flags_q.half <= (cnt_n >= HALF_C);
    end
  end
endmodule

// File: rtl/shift_fifo.sv
module shift_fifo
  import shift_fifo_pkg::*;
#(
  parameter int WIDTH     = 5,
  parameter int DEPTH     = 64,
  parameter int LOW_MARK  = 8,
  parameter int HIGH_MARK = 56,
  parameter int HALF_MARK = 32
) (
  input  logic             clk,
  input  logic             clear_n,
  input  logic             wr_strobe,
  input  logic [WIDTH-1:0] wr_data,
  output logic             wr_rdy,
  input  logic             rd_strobe,
  output logic             rd_rdy,
  input  logic             out_en_n,
  output logic [WIDTH-1:0] rd_data,
  output logic             edge_flag,
  output logic             half_flag
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

  logic          wr_rise, rd_rise;
  logic          wr_take, rd_take;
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [WIDTH-1:0] head_word;
  lvl_flags_t    flags_q;

  strobe_rise u_wr_edge (.clk(clk), .clear_n(clear_n), .strobe(wr_strobe), .rise(wr_rise));
  strobe_rise u_rd_edge (.clk(clk), .clear_n(clear_n), .strobe(rd_strobe), .rise(rd_rise));

  assign wr_take = wr_rise & wr_rdy;
  assign rd_take = rd_rise & rd_rdy;

  fifo_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (wr_take),
    .waddr (wr_ptr_q),
    .wdata (wr_data),
    .raddr (rd_ptr_q),
    .rdata (head_word)
  );

  fifo_level #(
    .DEPTH(DEPTH), .LOW_MARK(LOW_MARK), .HIGH_MARK(HIGH_MARK), .HALF_MARK(HALF_MARK)
  ) u_level (
    .clk     (clk),
    .clear_n (clear_n),
    .inc     (wr_take),
    .dec     (rd_take),
    .cnt_q   (cnt_q),
    .cnt_n   (cnt_n),
    .flags_q (flags_q)
  );

  always_ff @(posedge clk) begin
    if (!clear_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      wr_rdy   <= 1'b1;
      rd_rdy   <= 1'b0;
    end else begin
      if (wr_take) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (rd_take) rd_ptr_q <= rd_ptr_q + 1'b1;
      wr_rdy <= !wr_take && (cnt_n < FULL_C);
      if (rd_take)     rd_rdy <= 1'b0;
      else if (!rd_rdy) rd_rdy <= (cnt_q != '0);
    end
  end

  assign rd_data   = out_en_n ? '0 : head_word;
  assign edge_flag = flags_q.ends;
  assign half_flag = flags_q.half;
endmodule

// File: rtl/shift_fifo_chk.sv
module shift_fifo_chk #(
  parameter int DEPTH     = 64,
  parameter int LOW_MARK  = 8,
  parameter int HIGH_MARK = 56,
  parameter int HALF_MARK = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          clear_n,
  input logic          wr_strobe,
  input logic          wr_rdy,
  input logic          rd_strobe,
  input logic          rd_rdy,
  input logic [CW-1:0] cnt,
  input logic          edge_flag,
  input logic          half_flag
);
  logic pw, pr;
  always_ff @(posedge clk) begin
    if (!clear_n) begin
      pw <= 1'b0;
      pr <= 1'b0;
    end else begin
      pw <= wr_strobe;
      pr <= rd_strobe;
    end
  end

  assert_wr_drop_R2: assert property (@(posedge clk) disable iff (!clear_n)
    (wr_strobe && !pw && wr_rdy) |=> !wr_rdy);
  assert_wr_ignore_R3: assert property (@(posedge clk) disable iff (!clear_n)
    !wr_rdy |=> (cnt <= $past(cnt)));
  assert_full_hold_R4: assert property (@(posedge clk) disable iff (!clear_n)
    (int'(cnt) == DEPTH) |-> !wr_rdy);
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!clear_n)
    int'(cnt) <= DEPTH);
  assert_rd_drop_R6: assert property (@(posedge clk) disable iff (!clear_n)
    (rd_strobe && !pr && rd_rdy) |=> !rd_rdy);
  assert_rd_ignore_R7: assert property (@(posedge clk) disable iff (!clear_n)
    !rd_rdy |=> (cnt >= $past(cnt)));
  assert_edge_flag_R8: assert property (@(posedge clk) disable iff (!clear_n)
    edge_flag == ((int'(cnt) <= LOW_MARK) || (int'(cnt) >= HIGH_MARK)));
  assert_half_flag_R9: assert property (@(posedge clk) disable iff (!clear_n)
    half_flag == (int'(cnt) >= HALF_MARK));
endmodule

bind shift_fifo shift_fifo_chk #(
  .DEPTH(DEPTH), .LOW_MARK(LOW_MARK), .HIGH_MARK(HIGH_MARK), .HALF_MARK(HALF_MARK)
) u_chk (
  .clk       (clk),
  .clear_n   (clear_n),
  .wr_strobe (wr_strobe),
  .wr_rdy    (wr_rdy),
  .rd_strobe (rd_strobe),
  .rd_rdy    (rd_rdy),
  .cnt       (cnt_q),
  .edge_flag (edge_flag),
  .half_flag (half_flag)
);

// File: tb/tb_shift_fifo.sv
module tb_shift_fifo;
  logic clk = 1'b0;
  logic clear_n = 1'b0;
  logic wr_strobe = 1'b0;
  logic [4:0] wr_data = '0;
  logic wr_rdy;
  logic rd_strobe = 1'b0;
  logic rd_rdy;
  logic out_en_n = 1'b0;
  logic [4:0] rd_data;
  logic edge_flag, half_flag;

  int tests = 0;
  int fails = 0;
  int model[$];
  bit done = 0;

  always #5 clk = ~clk;

  shift_fifo dut (
    .clk(clk), .clear_n(clear_n), .wr_strobe(wr_strobe), .wr_data(wr_data),
    .wr_rdy(wr_rdy), .rd_strobe(rd_strobe), .rd_rdy(rd_rdy), .out_en_n(out_en_n),
    .rd_data(rd_data), .edge_flag(edge_flag), .half_flag(half_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_flags();
    int n = model.size();
    int e = ((n <= 8) || (n >= 56)) ? 1 : 0;
    int h = (n >= 32) ? 1 : 0;
    chk(int'(edge_flag) == e, "R8 edge_flag", int'(edge_flag), e);
    chk(int'(half_flag) == h, "R9 half_flag", int'(half_flag), h);
  endtask

  task automatic put(input logic [4:0] d, input int hold);
    @(negedge clk);
    while (!wr_rdy) @(negedge clk);
    wr_data = d;
    wr_strobe = 1'b1;
    @(negedge clk);
    model.push_back(int'(d));
    chk(wr_rdy == 1'b0, "R2 wr_rdy low after accept", int'(wr_rdy), 0);
    chk_flags();
    repeat (hold) @(negedge clk);
    wr_strobe = 1'b0;
  endtask

  task automatic take();
    @(negedge clk);
    chk(rd_rdy == 1'b1, "R6 rd_rdy before read", int'(rd_rdy), 1);
    chk(int'(rd_data) == model[0], "R5 word order", int'(rd_data), model[0]);
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    void'(model.pop_front());
    chk(rd_rdy == 1'b0, "R6 rd_rdy low one cycle", int'(rd_rdy), 0);
    chk_flags();
  endtask

  task automatic both(input logic [4:0] d);
    @(negedge clk);
    while (!(wr_rdy && rd_rdy)) @(negedge clk);
    chk(int'(rd_data) == model[0], "R5 word order", int'(rd_data), model[0]);
    wr_data = d;
    wr_strobe = 1'b1;
    rd_strobe = 1'b1;
    @(negedge clk);
    wr_strobe = 1'b0;
    rd_strobe = 1'b0;
    model.push_back(int'(d));
    void'(model.pop_front());
    chk_flags();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(wr_rdy == 1'b1, "R1 wr_rdy", int'(wr_rdy), 1);
    chk(rd_rdy == 1'b0, "R1 rd_rdy", int'(rd_rdy), 0);
    chk(edge_flag == 1'b1, "R1 edge_flag", int'(edge_flag), 1);
    chk(half_flag == 1'b0, "R1 half_flag", int'(half_flag), 0);
    clear_n = 1'b1;

    // R6 first word appears one cycle after entering empty store
    put(5'd3, 0);
    @(negedge clk);
    chk(wr_rdy == 1'b1, "R2 wr_rdy recovers", int'(wr_rdy), 1);
    chk(rd_rdy == 1'b1, "R6 rd_rdy after first write", int'(rd_rdy), 1);

    // R2 R8 R9 fill to full with a computed pattern
    for (int i = 1; i < 64; i++) put(5'((i * 7 + 3) & 31), 0);

    // R4 full: ready stays low, extra strobe ignored
    repeat (3) begin
      @(negedge clk);
      chk(wr_rdy == 1'b0, "R4 full holds wr_rdy low", int'(wr_rdy), 0);
    end
    wr_data = 5'd31;
    wr_strobe = 1'b1;
    @(negedge clk);
    wr_strobe = 1'b0;
    chk_flags();

    // R11 output enable forces zero
    out_en_n = 1'b1;
    @(negedge clk);
    chk(rd_data == 5'd0, "R11 disabled output zero", int'(rd_data), 0);
    out_en_n = 1'b0;

    // R4 first read reopens input
    take();
    chk(wr_rdy == 1'b1, "R4 wr_rdy after read from full", int'(wr_rdy), 1);

    // R5 R6 drain
    while (model.size() > 0) take();
    @(negedge clk);
    chk(rd_rdy == 1'b0, "R3 R6 empty after drain", int'(rd_rdy), 0);

    // R7 read while not ready ignored
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    chk(rd_rdy == 1'b0, "R7 rd_rdy still low", int'(rd_rdy), 0);
    chk_flags();
    put(5'd21, 0);
    take();
    @(negedge clk);
    chk(rd_rdy == 1'b0, "R7 no phantom word", int'(rd_rdy), 0);

    // R3 held strobe stores one word only
    put(5'd9, 4);
    take();
    @(negedge clk);
    chk(rd_rdy == 1'b0, "R3 held strobe stored one word", int'(rd_rdy), 0);

    // R10 simultaneous write and read at boundaries 32 and 56
    for (int i = 0; i < 32; i++) put(5'((i * 5 + 1) & 31), 0);
    both(5'd17);
    chk(half_flag == 1'b1, "R10 count kept at 32", int'(half_flag), 1);
    for (int i = 0; i < 24; i++) put(5'((i * 3 + 2) & 31), 0);
    both(5'd11);
    chk(edge_flag == 1'b1, "R10 count kept at 56", int'(edge_flag), 1);
    while (model.size() > 0) take();

    // R12 reset discards stored words
    put(5'd1, 0);
    put(5'd2, 0);
    @(negedge clk);
    clear_n = 1'b0;
    @(negedge clk);
    clear_n = 1'b1;
    model.delete();
    chk(rd_rdy == 1'b0, "R12 rd_rdy cleared", int'(rd_rdy), 0);
    chk(wr_rdy == 1'b1, "R12 wr_rdy after clear", int'(wr_rdy), 1);
    chk_flags();
    put(5'd26, 0);
    take();
    @(negedge clk);
    chk(rd_rdy == 1'b0, "R12 old words gone", int'(rd_rdy), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule